// File: doc/BRIEF.md
# Vector Gather Staging and Completion Unit

One copy of this unit sits in every memory bank controller. It is the staging buffer for strided vector operations. Up to eight vector operations can be in flight at once, and each is known by a 3-bit tag. When an operation is broadcast, every bank learns how many of that operation's elements it must handle. That count loads a per-tag counter of elements still owed.

**Gathered reads.** Each word the memory returns is stored under its tag and element slot, and the counter drops by one.

**Scattered writes.** The front end's write words are held in the unit. The bank's issue logic reads each word back by tag and slot when it sends it to memory, and each issue lowers the counter.

**Completion.** Each bank drives an active-high busy bit per tag while it still owes elements. Outside the block, these bits are combined as a wired-OR, so the shared completion line for a tag falls only when every bank has finished that tag. A bank that owes nothing on an operation never raises its bit. After the line falls on a read, the front end broadcasts a stage-read with the tag. Each bank then streams its held elements onto a merge bus, one beat per cycle. Every beat carries the element's slot number, so a merger can place it in the cache line. Streaming frees the entry.

Top module: `gather_stage_unit`

## Requirements
- R1: After reset every busy bit is 0 and the merge bus is idle (`mb_valid` = 0).
- R2: An operation command with a nonzero count sets `busy[tag]` from the cycle after the command.
- R3: An operation command with a count of zero leaves `busy[tag]` at 0.
- R4: Each accepted read return stores its word at (tag, slot) and lowers the tag's count by one. `busy[tag]` falls in the cycle after the last owed return. The shared line for a tag is low only when no bank is busy on it.
- R5: A read return for a tag whose count is already zero is ignored: nothing is stored and no merge beat is produced for it.
- R6: Write data from the front end is held at (tag, slot), and `iss_data` shows the held word for the presented `iss_tag`/`iss_idx` in the same cycle.
- R7: Each write issue on a tag with a nonzero count lowers the count by one and releases the slot. `busy[tag]` falls in the cycle after the last issue.
- R8: A stage-read for a tag with held elements produces one beat per cycle, starting the cycle after the command. Beats come in ascending slot order, each carrying the slot and its word, with `mb_last` = 1 on the final beat and `mb_valid` low the cycle after it.
- R9: Streaming frees the tag: a second stage-read of the same tag produces no beats.
- R10: A stage-read that arrives while a stream is in progress, including the final-beat cycle, is ignored.
- R11: Tags are independent: counts, held words and streams of one tag are unaffected by activity on other tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Vector operation broadcast |
| cmd_tag | input | 3 | Tag of the broadcast operation |
| cmd_count | input | 4 | Elements this bank owes on it (0 to 8) |
| rd_valid | input | 1 | Memory read return |
| rd_tag | input | 3 | Tag of the returned word |
| rd_idx | input | 3 | Element slot of the returned word |
| rd_data | input | 32 | Returned word |
| wr_valid | input | 1 | Front-end write word |
| wr_tag | input | 3 | Tag of the write word |
| wr_idx | input | 3 | Element slot of the write word |
| wr_data | input | 32 | Write word |
| iss_valid | input | 1 | Bank issues one buffered write element to memory |
| iss_tag | input | 3 | Tag being issued |
| iss_idx | input | 3 | Slot being issued |
| iss_data | output | 32 | Held word at (iss_tag, iss_idx) |
| busy | output | 8 | Per-tag busy bit, this bank's share of the wired-OR completion line |
| stg_valid | input | 1 | Stage-read command |
| stg_tag | input | 3 | Tag to stream |
| mb_valid | output | 1 | Merge-bus beat valid |
| mb_idx | output | 3 | Slot of the beat |
| mb_data | output | 32 | Word of the beat |
| mb_last | output | 1 | Final beat of the stream |

## Verification
Busy changes, stored returns and stream starts all appear one cycle after the input that causes them, since each passes through exactly one register. `iss_data` is combinational from the issue address. The bench drives inputs just after the rising edge. It compares a behavioural model against both bank instances at every falling edge, so each output is sampled half a cycle after the edge that updated it. Directed checks follow each stimulus by exactly one cycle. `iss_data` is read a quarter period after its address is driven.

// File: rtl/gather_stage_unit.sv
module gather_stage_unit #(
  parameter int TAGS   = 8,
  parameter int ELEMS  = 8,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(TAGS),
  localparam int IDX_W = $clog2(ELEMS),
  localparam int CNT_W = $clog2(ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              iss_valid,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  iss_idx,
  output logic [DATA_W-1:0] iss_data,
  output logic [TAGS-1:0]   busy,
  input  logic              stg_valid,
  input  logic [TAG_W-1:0]  stg_tag,
  output logic              mb_valid,
  output logic [IDX_W-1:0]  mb_idx,
  output logic [DATA_W-1:0] mb_data,
  output logic              mb_last
);

  logic [CNT_W-1:0]  owe     [TAGS];
  logic [CNT_W-1:0]  owe_nx  [TAGS];
  logic [ELEMS-1:0]  held    [TAGS];
  logic [ELEMS-1:0]  held_nx [TAGS];
  logic [DATA_W-1:0] store   [TAGS*ELEMS];
  logic              s_act;
  logic [TAG_W-1:0]  s_tag;
  logic [ELEMS-1:0]  s_mask;
  logic [IDX_W-1:0]  s_idx;

  wire rd_take  = rd_valid && (owe[rd_tag] != '0);
  wire iss_take = iss_valid && (owe[iss_tag] != '0);
  wire stg_take = stg_valid && !s_act && (held[stg_tag] != '0);

  assign s_mask   = held[s_tag];
  assign mb_valid = s_act;
  assign mb_idx   = s_idx;
  assign mb_data  = store[{s_tag, s_idx}];
  assign mb_last  = s_act && ((s_mask & (s_mask - 1'b1)) == '0);
  assign iss_data = store[{iss_tag, iss_idx}];

  always_comb begin
    s_idx = '0;
    for (int i = ELEMS - 1; i >= 0; i--)
      if (s_mask[i]) s_idx = IDX_W'(i);
  end

  always_comb begin
    for (int t = 0; t < TAGS; t++) begin
      owe_nx[t]  = owe[t];
      held_nx[t] = held[t];
      if (cmd_valid && cmd_tag == TAG_W'(t)) begin
        owe_nx[t]  = cmd_count;
        held_nx[t] = '0;
      end else begin
        if (rd_take && rd_tag == TAG_W'(t)) begin
          owe_nx[t] = owe_nx[t] - 1'b1;
          held_nx[t][rd_idx] = 1'b1;
        end
        if (wr_valid && wr_tag == TAG_W'(t)) held_nx[t][wr_idx] = 1'b1;
        if (iss_take && iss_tag == TAG_W'(t)) begin
          owe_nx[t] = owe_nx[t] - 1'b1;
          held_nx[t][iss_idx] = 1'b0;
        end
        if (s_act && s_tag == TAG_W'(t)) held_nx[t][s_idx] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < TAGS; t++) begin
        owe[t]  <= '0;
        held[t] <= '0;
      end
      s_act <= 1'b0;
      s_tag <= '0;
    end else begin
      for (int t = 0; t < TAGS; t++) begin
        owe[t]  <= owe_nx[t];
        held[t] <= held_nx[t];
      end
      if (s_act) begin
        if (mb_last) s_act <= 1'b0;
      end else if (stg_take) begin
        s_act <= 1'b1;
        s_tag <= stg_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_take)  store[{rd_tag, rd_idx}] <= rd_data;
    if (wr_valid) store[{wr_tag, wr_idx}] <= wr_data;
  end

  for (genvar t = 0; t < TAGS; t++) begin : g_busy
    assign busy[t] = (owe[t] != '0);

    AST_FALL_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[t]) |-> $past((rd_valid && rd_tag == TAG_W'(t)) ||
                               (iss_valid && iss_tag == TAG_W'(t)) ||
                               (cmd_valid && cmd_tag == TAG_W'(t)))); // R4
  end

  AST_BUSY_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_count != '0 |=> busy[$past(cmd_tag)]); // R2
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_count == '0 |=> !busy[$past(cmd_tag)]); // R3
  AST_STREAM_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid && !mb_last |=> mb_valid && (mb_idx > $past(mb_idx))); // R8
  AST_STREAM_END: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid && mb_last |=> !mb_valid); // R10

endmodule

// File: tb/sim_gather_stage_unit.sv
module sim_gather_stage_unit;
  localparam int PERIOD = 10;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic cmd_v = 0, stg_v = 0;
  logic [2:0] cmd_t = 0, stg_t = 0;
  logic [3:0] cmd_c [NB];
  logic rd_v [NB], wr_v [NB], is_v [NB];
  logic [2:0] rd_t [NB], rd_i [NB], wr_t [NB], wr_i [NB], is_t [NB], is_i [NB];
  logic [31:0] rd_d [NB], wr_d [NB], is_d [NB], mbd [NB];
  logic [7:0] bsy [NB];
  logic mbv [NB], mbl [NB];
  logic [2:0] mbi [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    if (b == 0) begin : g_u0
      gather_stage_unit u0 (.clk, .rst_n, .cmd_valid(cmd_v), .cmd_tag(cmd_t), .cmd_count(cmd_c[b]),
        .rd_valid(rd_v[b]), .rd_tag(rd_t[b]), .rd_idx(rd_i[b]), .rd_data(rd_d[b]),
        .wr_valid(wr_v[b]), .wr_tag(wr_t[b]), .wr_idx(wr_i[b]), .wr_data(wr_d[b]),
        .iss_valid(is_v[b]), .iss_tag(is_t[b]), .iss_idx(is_i[b]), .iss_data(is_d[b]),
        .busy(bsy[b]), .stg_valid(stg_v), .stg_tag(stg_t),
        .mb_valid(mbv[b]), .mb_idx(mbi[b]), .mb_data(mbd[b]), .mb_last(mbl[b]));
    end else begin : g_u1
      gather_stage_unit u1 (.clk, .rst_n, .cmd_valid(cmd_v), .cmd_tag(cmd_t), .cmd_count(cmd_c[b]),
        .rd_valid(rd_v[b]), .rd_tag(rd_t[b]), .rd_idx(rd_i[b]), .rd_data(rd_d[b]),
        .wr_valid(wr_v[b]), .wr_tag(wr_t[b]), .wr_idx(wr_i[b]), .wr_data(wr_d[b]),
        .iss_valid(is_v[b]), .iss_tag(is_t[b]), .iss_idx(is_i[b]), .iss_data(is_d[b]),
        .busy(bsy[b]), .stg_valid(stg_v), .stg_tag(stg_t),
        .mb_valid(mbv[b]), .mb_idx(mbi[b]), .mb_data(mbd[b]), .mb_last(mbl[b]));
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_owe  [NB][8];
  logic [7:0]  m_held [NB][8];
  logic [31:0] m_mem  [NB][8][8];
  bit          m_act  [NB];
  int          m_stag [NB];

  function automatic int low(logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        for (int t = 0; t < 8; t++) begin m_owe[b][t] = 0; m_held[b][t] = '0; end
        m_act[b] = 0; m_stag[b] = 0;
      end else begin
        bit acc, rdok, isok, oact;
        int otag;
        logic [7:0] omask;
        oact = m_act[b]; otag = m_stag[b]; omask = m_held[b][otag];
        acc  = stg_v && !oact && (m_held[b][stg_t] != 0);
        rdok = rd_v[b] && (m_owe[b][rd_t[b]] != 0);
        isok = is_v[b] && (m_owe[b][is_t[b]] != 0);
        if (rdok) begin
          m_mem[b][rd_t[b]][rd_i[b]] = rd_d[b];
          m_held[b][rd_t[b]][rd_i[b]] = 1'b1;
          m_owe[b][rd_t[b]]--;
        end
        if (wr_v[b]) begin
          m_mem[b][wr_t[b]][wr_i[b]] = wr_d[b];
          m_held[b][wr_t[b]][wr_i[b]] = 1'b1;
        end
        if (isok) begin
          m_held[b][is_t[b]][is_i[b]] = 1'b0;
          m_owe[b][is_t[b]]--;
        end
        if (oact) begin
          m_held[b][otag][low(omask)] = 1'b0;
          if ($countones(omask) == 1) m_act[b] = 0;
        end else if (acc) begin
          m_act[b] = 1; m_stag[b] = stg_t;
        end
        if (cmd_v) begin
          m_owe[b][cmd_t] = cmd_c[b];
          m_held[b][cmd_t] = '0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NB; b++) begin
        logic [7:0] eb;
        for (int t = 0; t < 8; t++) eb[t] = (m_owe[b][t] != 0);
        chk("R11 busy vs model", bsy[b], eb);
        chk("R8 mb_valid vs model", mbv[b], m_act[b]);
        if (m_act[b]) begin
          logic [7:0] mk;
          mk = m_held[b][m_stag[b]];
          chk("R8 mb_idx vs model", mbi[b], low(mk));
          chk("R8 mb_data vs model", mbd[b], m_mem[b][m_stag[b]][low(mk)]);
          chk("R8 mb_last vs model", mbl[b], $countones(mk) == 1);
        end
        if (is_v[b] && m_held[b][is_t[b]][is_i[b]])
          chk("R6 iss_data vs model", is_d[b], m_mem[b][is_t[b]][is_i[b]]);
      end
    end
  end

  task automatic clear();
    cmd_v = 0; stg_v = 0;
    for (int b = 0; b < NB; b++) begin rd_v[b] = 0; wr_v[b] = 0; is_v[b] = 0; end
  endtask

  task automatic cyc();
    @(posedge clk); #1; clear();
    @(negedge clk); #1;
  endtask

  function automatic logic line_low(int t);
    return !(bsy[0][t] | bsy[1][t]);
  endfunction

  task automatic ret(int b, int t, int i, logic [31:0] d);
    rd_v[b] = 1; rd_t[b] = 3'(t); rd_i[b] = 3'(i); rd_d[b] = d;
  endtask

  task automatic beat(int b, logic v, int i, logic [31:0] d, logic l, string req);
    chk(req, mbv[b], v);
    if (v) begin chk(req, mbi[b], i); chk(req, mbd[b], d); chk(req, mbl[b], l); end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      cmd_c[b] = 0; rd_t[b] = 0; rd_i[b] = 0; rd_d[b] = 0; wr_t[b] = 0; wr_i[b] = 0;
      wr_d[b] = 0; is_t[b] = 0; is_i[b] = 0;
    end
    clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    for (int b = 0; b < NB; b++) begin
      chk("R1 busy after reset", bsy[b], 8'h00);
      chk("R1 mb_valid after reset", mbv[b], 1'b0);
    end

    // gathered read on tag 2
    cmd_v = 1; cmd_t = 2; cmd_c[0] = 3; cmd_c[1] = 2; cyc();
    chk("R2 busy raised bank0", bsy[0][2], 1'b1);
    chk("R2 busy raised bank1", bsy[1][2], 1'b1);
    ret(0, 2, 0, 32'hA000_0000); ret(1, 2, 1, 32'hB000_0001); cyc();
    chk("R4 still busy bank1", bsy[1][2], 1'b1);
    ret(0, 2, 2, 32'hA000_0002); ret(1, 2, 3, 32'hB000_0003); cyc();
    chk("R4 bank1 released", bsy[1][2], 1'b0);
    chk("R4 line still high", line_low(2), 1'b0);
    ret(0, 2, 4, 32'hA000_0004); cyc();
    chk("R4 bank0 released", bsy[0][2], 1'b0);
    chk("R4 line low", line_low(2), 1'b1);
    stg_v = 1; stg_t = 2; cyc();
    beat(0, 1, 0, 32'hA000_0000, 0, "R8 beat0 bank0");
    beat(1, 1, 1, 32'hB000_0001, 0, "R8 beat0 bank1");
    cyc();
    beat(0, 1, 2, 32'hA000_0002, 0, "R8 beat1 bank0");
    beat(1, 1, 3, 32'hB000_0003, 1, "R8 last bank1");
    cyc();
    beat(0, 1, 4, 32'hA000_0004, 1, "R8 last bank0");
    beat(1, 0, 0, 0, 0, "R8 bank1 ended");
    cyc();
    beat(0, 0, 0, 0, 0, "R8 bank0 ended");
    stg_v = 1; stg_t = 2; cyc();
    beat(0, 0, 0, 0, 0, "R9 freed bank0");
    beat(1, 0, 0, 0, 0, "R9 freed bank1");

    // zero count and ignored return on tag 4
    cmd_v = 1; cmd_t = 4; cmd_c[0] = 0; cmd_c[1] = 1; cyc();
    chk("R3 zero count stays idle", bsy[0][4], 1'b0);
    chk("R2 bank1 busy", bsy[1][4], 1'b1);
    ret(0, 4, 6, 32'hDEAD_0006); ret(1, 4, 1, 32'hC000_0001); cyc();
    chk("R5 no busy from stray return", bsy[0][4], 1'b0);
    chk("R4 line low tag4", line_low(4), 1'b1);
    stg_v = 1; stg_t = 4; cyc();
    beat(0, 0, 0, 0, 0, "R5 stray return not staged");
    beat(1, 1, 1, 32'hC000_0001, 1, "R8 single beat");
    cyc();

    // scattered write on tag 6, bank0 only
    cmd_v = 1; cmd_t = 6; cmd_c[0] = 2; cmd_c[1] = 0; cyc();
    wr_v[0] = 1; wr_t[0] = 6; wr_i[0] = 3; wr_d[0] = 32'h1111_0003; cyc();
    wr_v[0] = 1; wr_t[0] = 6; wr_i[0] = 5; wr_d[0] = 32'h2222_0005; cyc();
    chk("R7 busy before issue", bsy[0][6], 1'b1);
    is_v[0] = 1; is_t[0] = 6; is_i[0] = 5;
    #(PERIOD/4) chk("R6 iss_data slot5", is_d[0], 32'h2222_0005);
    cyc();
    chk("R7 busy after one issue", bsy[0][6], 1'b1);
    is_v[0] = 1; is_t[0] = 6; is_i[0] = 3;
    #(PERIOD/4) chk("R6 iss_data slot3", is_d[0], 32'h1111_0003);
    cyc();
    chk("R7 busy released", bsy[0][6], 1'b0);
    chk("R7 line low tag6", line_low(6), 1'b1);

    // two tags interleaved, stage-read during stream
    cmd_v = 1; cmd_t = 1; cmd_c[0] = 2; cmd_c[1] = 0; cyc();
    cmd_v = 1; cmd_t = 3; cmd_c[0] = 1; cmd_c[1] = 0; cyc();
    chk("R11 both tags busy", {bsy[0][3], bsy[0][1]}, 2'b11);
    ret(0, 1, 0, 32'h5100_0000); cyc();
    ret(0, 3, 7, 32'h5300_0007); cyc();
    chk("R11 tag3 done tag1 busy", {bsy[0][3], bsy[0][1]}, 2'b01);
    ret(0, 1, 1, 32'h5100_0001); cyc();
    chk("R11 both done", {bsy[0][3], bsy[0][1]}, 2'b00);
    stg_v = 1; stg_t = 1; cyc();
    beat(0, 1, 0, 32'h5100_0000, 0, "R8 tag1 beat0");
    stg_v = 1; stg_t = 3; cyc();
    beat(0, 1, 1, 32'h5100_0001, 1, "R10 stream undisturbed");
    stg_v = 1; stg_t = 3; cyc();
    beat(0, 0, 0, 0, 0, "R10 stage ignored during last beat");
    cyc();
    beat(0, 0, 0, 0, 0, "R10 no late stream");
    stg_v = 1; stg_t = 3; cyc();
    beat(0, 1, 7, 32'h5300_0007, 1, "R11 tag3 kept its word");
    cyc();
    beat(0, 0, 0, 0, 0, "R8 tag3 ended");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule